// File: doc/BRIEF.md
# Adaptive Break-Before-Make Gate Sequencer

This block decides, every clock, whether the high-side and the low-side switch of a synchronous buck stage may be driven on. It takes a two-bit drive command (turn the high side on, turn the low side on, or switch both off), a digitized supply-level code, and three digitized feedback flags that come from comparators on the gate and switch nodes. From these it produces two gate-enable outputs and a dead-time fault flag.

Dead time is closed-loop. A switch is enabled only after a synchronized feedback flag shows that the opposite switch is really off, so the gap between one switch turning off and the other turning on follows the real power stage and not a fixed delay. A timer watches every such wait and raises a fault flag when a flag is late, while the waiting gate stays off. Start-up is guarded twice. The supply code must clear a rising threshold, with hysteresis against a lower falling threshold. After that, the command must pass through the off state and then leave it before any switching is allowed. A supply drop at any time returns the block to that guarded start.

Top module: `gate_bbm_sequencer`

## Requirements
- R1: A registered supply-good flag sets one cycle after `vsup_code` >= POR_RISE (default 86) and clears one cycle after `vsup_code` < POR_FALL (default 71). Between the two thresholds it keeps its value. While the flag is clear, both `hs_en` and `ls_en` are low from the next cycle on.
- R2: After supply-good sets, both enables stay low, and HIGH or LOW commands are ignored, until the command has been OFF and has then changed to HIGH or LOW.
- R3: On a change from HIGH to LOW, `hs_en` drops on the next clock edge. `ls_en` rises only on the edge after the synchronized high-side-off flag is seen while LOW is still commanded.
- R4: The high-side-off flag is `hg_near_sw` OR `sw_low`. Either input alone is enough.
- R5: On a change from LOW to HIGH, `ls_en` drops on the next clock edge. `hs_en` rises only on the edge after the synchronized `lg_low` flag is seen while HIGH is still commanded.
- R6: An OFF command drives both enables low on the next clock edge, from any state, with no sequencing.
- R7: Once armed, switching continues through any number of OFF periods until supply-good clears. After supply-good clears, arming (R2) is required again.
- R8: `hs_en` and `ls_en` are never high in the same cycle.
- R9: If the sequencer stays in one wait state for TIMEOUT cycles after the cycle it entered, `dly_fault` goes high in the next cycle and the waiting gate stays off. `dly_fault` clears when the wait ends.
- R10: A new command during a wait re-targets the sequence. The new target's gate turns on only after the flag for its own opposite switch is seen.
- R11: Command encoding on `drive_cmd`: 2'b00 = LOW (low side on), 2'b01 = HIGH (high side on), 2'b10 and 2'b11 = OFF.
- R12: Each feedback input passes through SYNC_STAGES flip-flops (default 2) before the sequencer uses it. A flag change therefore shows at an enable no earlier than SYNC_STAGES+1 edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsup_code | input | 8 | Digitized supply level, one code per 100 mV |
| drive_cmd | input | 2 | Drive command (R11 encoding) |
| hg_near_sw | input | 1 | High gate is less than 1.7 V above the switch node |
| sw_low | input | 1 | Switch node is below 0.8 V |
| lg_low | input | 1 | Low gate is below 1.7 V |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| dly_fault | output | 1 | An off-detection flag is overdue |

## Verification
A wrong state in the sequencer shows at the enables within one edge. If an enable comes up one cycle too early, it shows as a turn-on that does not follow the flag by SYNC_STAGES+1 edges, or as both enables high at once. A wrong hold state shows as an enable that stays low after an arming pass, or after a flag that should release it. A timer that counts wrongly moves `dly_fault` by at least one cycle against TIMEOUT. A wrong hysteresis shows as enables that drop, or fail to stay off, at a supply code between the two thresholds. The reference model follows all outputs on every clock, so any of these shows as a mismatch in the first cycle where it occurs.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HOLD  = 3'd0,
        ST_WAIT_ARM    = 3'd1,
        ST_HS_ON       = 3'd2,
        ST_HS_OFF_WAIT = 3'd3,
        ST_LS_ON       = 3'd4,
        ST_LS_OFF_WAIT = 3'd5,
        ST_DISABLED    = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        REQ_LOW  = 2'd0,
        REQ_HIGH = 2'd1,
        REQ_OFF  = 2'd2
    } req_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    typedef struct packed {
        logic hs_off;
        logic ls_off;
    } off_flags_t;

    // R11: bit 1 set means OFF, otherwise bit 0 chooses the high side
    function automatic req_t decode_cmd(input logic [1:0] raw);
        if (raw[1])
            return REQ_OFF;
        else if (raw[0])
            return REQ_HIGH;
        else
            return REQ_LOW;
    endfunction

    function automatic logic is_wait(input seq_state_t s);
        return (s == ST_HS_OFF_WAIT) || (s == ST_LS_OFF_WAIT);
    endfunction

    function automatic gate_pair_t gates_of(input seq_state_t s);
        gate_pair_t g;
        g.hs = (s == ST_HS_ON);
        g.ls = (s == ST_LS_ON);
        return g;
    endfunction

endpackage

// File: rtl/bbm_supply_monitor.sv
module bbm_supply_monitor #(
    parameter int VW       = 8,
    parameter int POR_RISE = 86,
    parameter int POR_FALL = 71
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vsup_code,
    output logic          supply_good
);
    localparam logic [VW-1:0] RISE_C = VW'(POR_RISE);
    localparam logic [VW-1:0] FALL_C = VW'(POR_FALL);

    logic above_rise;
    logic below_fall;

    assign above_rise = (vsup_code >= RISE_C);
    assign below_fall = (vsup_code <  FALL_C);

    always_ff @(posedge clk) begin
        if (rst)
            supply_good <= 1'b0;
        else if (!supply_good && above_rise)
            supply_good <= 1'b1;
        else if (supply_good && below_fall)
            supply_good <= 1'b0;
    end

    // R1: the flag keeps its value inside the hysteresis band
    p_por_keep_on_r1: assert property (@(posedge clk) disable iff (rst)
        (supply_good && !below_fall) |=> supply_good);
    p_por_keep_off_r1: assert property (@(posedge clk) disable iff (rst)
        (!supply_good && !above_rise) |=> !supply_good);

endmodule

// File: rtl/bbm_feedback_sync.sv
module bbm_feedback_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= '0;
                else
                    chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= '0;
                else
                    chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/bbm_wait_timer.sv
module bbm_wait_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_wait,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart || !in_wait)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign expired = in_wait && (cnt == LIMIT);

    // R9: the count never runs past its limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == LIMIT && in_wait && !restart) |=> (cnt == LIMIT));

endmodule

// File: rtl/bbm_sequencer_fsm.sv
module bbm_sequencer_fsm
    import bbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_good,
    input  req_t       req,
    input  off_flags_t flags,
    output seq_state_t state,
    output seq_state_t nxt,
    output gate_pair_t gates
);

    always_comb begin
        nxt = state;
        if (!supply_good) begin
            nxt = ST_RESET_HOLD;
        end else begin
            case (state)
                ST_RESET_HOLD:  nxt = ST_WAIT_ARM;
                // R2: arming needs an OFF first
                ST_WAIT_ARM:    if (req == REQ_OFF) nxt = ST_DISABLED;
                ST_DISABLED: begin
                    if (req == REQ_HIGH)     nxt = ST_LS_OFF_WAIT;
                    else if (req == REQ_LOW) nxt = ST_HS_OFF_WAIT;
                end
                ST_HS_ON: begin
                    if (req == REQ_OFF)      nxt = ST_DISABLED;
                    else if (req == REQ_LOW) nxt = ST_HS_OFF_WAIT;
                end
                ST_HS_OFF_WAIT: begin
                    if (req == REQ_OFF)       nxt = ST_DISABLED;
                    else if (req == REQ_HIGH) nxt = ST_LS_OFF_WAIT;
                    else if (flags.hs_off)    nxt = ST_LS_ON;
                end
                ST_LS_ON: begin
                    if (req == REQ_OFF)       nxt = ST_DISABLED;
                    else if (req == REQ_HIGH) nxt = ST_LS_OFF_WAIT;
                end
                ST_LS_OFF_WAIT: begin
                    if (req == REQ_OFF)      nxt = ST_DISABLED;
                    else if (req == REQ_LOW) nxt = ST_HS_OFF_WAIT;
                    else if (flags.ls_off)   nxt = ST_HS_ON;
                end
                default:        nxt = ST_RESET_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET_HOLD;
            gates <= '0;
        end else begin
            state <= nxt;
            gates <= gates_of(nxt);
        end
    end

    // R8: never both on
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(gates.hs && gates.ls));
    // R5: high side rises only after low-side-off was seen
    p_hs_after_lsoff_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.hs) |-> $past(flags.ls_off));
    // R3: low side rises only after high-side-off was seen
    p_ls_after_hsoff_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.ls) |-> $past(flags.hs_off));
    // R6: OFF clears both gates at the next edge
    p_off_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        (req == REQ_OFF) |=> (!gates.hs && !gates.ls));
    // R1: no supply, no gates
    p_por_gates_r1: assert property (@(posedge clk) disable iff (rst)
        !supply_good |=> (!gates.hs && !gates.ls));
    // R11: the high side rises only under a HIGH command
    p_hs_needs_high_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.hs) |-> ($past(req) == REQ_HIGH));

endmodule

// File: rtl/gate_bbm_sequencer.sv
module gate_bbm_sequencer
    import bbm_pkg::*;
#(
    parameter int VW          = 8,
    parameter int POR_RISE    = 86,
    parameter int POR_FALL    = 71,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vsup_code,
    input  logic [1:0]    drive_cmd,
    input  logic          hg_near_sw,
    input  logic          sw_low,
    input  logic          lg_low,
    output logic          hs_en,
    output logic          ls_en,
    output logic          dly_fault
);
    logic       supply_good;
    off_flags_t raw_flags;
    off_flags_t sync_flags;
    seq_state_t state;
    seq_state_t nxt;
    gate_pair_t gates;
    req_t       req;

    // R4: either comparator alone marks the high side off
    assign raw_flags.hs_off = hg_near_sw | sw_low;
    assign raw_flags.ls_off = lg_low;
    assign req              = decode_cmd(drive_cmd);

    bbm_supply_monitor #(
        .VW       (VW),
        .POR_RISE (POR_RISE),
        .POR_FALL (POR_FALL)
    ) supply_i (
        .clk         (clk),
        .rst         (rst),
        .vsup_code   (vsup_code),
        .supply_good (supply_good)
    );

    bbm_feedback_sync #(
        .STAGES (SYNC_STAGES),
        .W      ($bits(off_flags_t))
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_flags),
        .dout (sync_flags)
    );

    bbm_sequencer_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .supply_good (supply_good),
        .req         (req),
        .flags       (sync_flags),
        .state       (state),
        .nxt         (nxt),
        .gates       (gates)
    );

    bbm_wait_timer #(
        .TIMEOUT (TIMEOUT)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .in_wait (is_wait(state)),
        .restart (nxt != state),
        .expired (dly_fault)
    );

    assign hs_en = gates.hs;
    assign ls_en = gates.ls;

    // R9: a late flag never lets a gate on
    p_fault_gates_off_r9: assert property (@(posedge clk) disable iff (rst)
        dly_fault |-> (!hs_en && !ls_en));

endmodule

// File: tb/gate_bbm_sequencer_tb_top.sv
module gate_bbm_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int TO         = 8;
    localparam int RISE       = 86;
    localparam int FALL       = 71;

    // model state codes
    localparam int M_HOLD = 0, M_ARM = 1, M_HON = 2, M_HWT = 3,
                   M_LON = 4, M_LWT = 5, M_OFF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] vsup_code = 8'd0;
    logic [1:0] drive_cmd = 2'b10;
    logic       hg_near_sw = 1'b0;
    logic       sw_low = 1'b0;
    logic       lg_low = 1'b0;
    logic       hs_en, ls_en, dly_fault;

    int errors = 0;
    int checks = 0;
    string tag = "R1";
    bit checking = 0;

    int m_por, m_st, m_cnt;
    logic [SYNC-1:0] m_hq, m_lq;

    gate_bbm_sequencer #(
        .VW(8), .POR_RISE(RISE), .POR_FALL(FALL),
        .SYNC_STAGES(SYNC), .TIMEOUT(TO)
    ) dut_i (
        .clk(clk), .rst(rst), .vsup_code(vsup_code), .drive_cmd(drive_cmd),
        .hg_near_sw(hg_near_sw), .sw_low(sw_low), .lg_low(lg_low),
        .hs_en(hs_en), .ls_en(ls_en), .dly_fault(dly_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, advanced once per rising edge
    always @(posedge clk) begin
        int kind, nst;
        bit hf, lf, waiting;
        if (rst) begin
            m_por = 0; m_st = M_HOLD; m_cnt = 0; m_hq = '0; m_lq = '0;
        end else begin
            kind = drive_cmd[1] ? 2 : (drive_cmd[0] ? 1 : 0); // 0 low, 1 high, 2 off
            hf = m_hq[SYNC-1];
            lf = m_lq[SYNC-1];
            nst = m_st;
            if (m_por == 0) nst = M_HOLD;
            else if (m_st == M_HOLD) nst = M_ARM;
            else if (m_st == M_ARM) begin
                if (kind == 2) nst = M_OFF;
            end else if (kind == 2) nst = M_OFF;
            else if (kind == 1) begin
                if (m_st == M_LWT) nst = lf ? M_HON : M_LWT;
                else if (m_st != M_HON) nst = M_LWT;
            end else begin
                if (m_st == M_HWT) nst = hf ? M_LON : M_HWT;
                else if (m_st != M_LON) nst = M_HWT;
            end
            waiting = (m_st == M_HWT) || (m_st == M_LWT);
            if (nst != m_st || !waiting) m_cnt = 0;
            else if (m_cnt < TO) m_cnt = m_cnt + 1;
            if (m_por == 0 && vsup_code >= RISE) m_por = 1;
            else if (m_por == 1 && vsup_code < FALL) m_por = 0;
            m_hq = (m_hq << 1) | SYNC'(hg_near_sw | sw_low);
            m_lq = (m_lq << 1) | SYNC'(lg_low);
            m_st = nst;
        end
    end

    task automatic check1(input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            check1("hs_en", hs_en, m_st == M_HON);
            check1("ls_en", ls_en, m_st == M_LON);
            check1("dly_fault", dly_fault,
                   ((m_st == M_HWT) || (m_st == M_LWT)) && (m_cnt == TO));
            // R8: both enables never high together
            checks++;
            if (hs_en === 1'b1 && ls_en === 1'b1) begin
                errors++;
                $display("FAIL R8 overlap: got hs=1 ls=1 expected not both");
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic flags(input logic h, input logic s, input logic l);
        hg_near_sw = h; sw_low = s; lg_low = l;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(posedge clk); #2;
        checking = 1;
        tag = "R1"; cyc(3);
        rst = 1'b0;
        vsup_code = 8'd80; drive_cmd = 2'b01; flags(0, 0, 1);
        cyc(5);                                   // R1: between thresholds, still off
        vsup_code = 8'd86; cyc(2);
        tag = "R2"; cyc(6);                       // R2: HIGH ignored before arming
        drive_cmd = 2'b00; cyc(4);
        drive_cmd = 2'b10; cyc(3);
        tag = "R5"; drive_cmd = 2'b01; cyc(6);    // first exit arms; hs after lg_low
        tag = "R3"; flags(0, 0, 0); drive_cmd = 2'b00; cyc(4);
        tag = "R4"; flags(0, 1, 0); cyc(5);       // sw_low alone releases low side
        tag = "R12"; flags(0, 0, 0); drive_cmd = 2'b01; cyc(3);
        lg_low = 1'b1; cyc(1); cyc(1); cyc(1); cyc(2);
        tag = "R4"; flags(0, 0, 0); drive_cmd = 2'b00; cyc(3);
        flags(1, 0, 0); cyc(5);                   // hg_near_sw alone
        tag = "R9"; flags(0, 0, 0); drive_cmd = 2'b01; cyc(TO + 6);
        lg_low = 1'b1; cyc(5);
        tag = "R10"; flags(0, 0, 0); drive_cmd = 2'b00; cyc(3);
        drive_cmd = 2'b01; cyc(3);                // re-target while waiting
        lg_low = 1'b1; cyc(5);
        flags(1, 1, 0); drive_cmd = 2'b00; cyc(1);
        drive_cmd = 2'b01; flags(1, 1, 1); cyc(5);
        tag = "R6"; drive_cmd = 2'b10; cyc(3);
        drive_cmd = 2'b01; cyc(5);
        tag = "R11"; drive_cmd = 2'b11; cyc(3);
        drive_cmd = 2'b00; flags(1, 0, 0); cyc(5);
        drive_cmd = 2'b10; cyc(2);
        tag = "R7"; drive_cmd = 2'b00; vsup_code = 8'd72; cyc(6);
        vsup_code = 8'd70; cyc(4);
        vsup_code = 8'd95; cyc(3);
        drive_cmd = 2'b01; flags(0, 0, 1); cyc(6);
        drive_cmd = 2'b10; cyc(2);
        drive_cmd = 2'b01; cyc(6);
        tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 300) == 0) vsup_code = 8'(65 + ($urandom % 35));
            if (($urandom % 6) == 0) drive_cmd = 2'($urandom);
            flags(1'($urandom % 3 == 0), 1'($urandom % 4 == 0), 1'($urandom % 3 == 0));
            cyc(1);
        end
        checking = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule